// File: doc/BRIEF.md
# SMBus Block Transfer Buffer Controller

This controller sits between a host register interface and a byte-level SMBus shift engine and carries out complete Block Write and Block Read transactions. The host preloads outgoing bytes into a 32-entry byte buffer, or drains incoming bytes from it, through a simple write port and a simple read port. It then supplies the target address, the command code, the direction and, for a write, the byte count, and pulses `start`. The controller asks the shift engine for one byte operation at a time: a start condition with the address, the command code, a byte-count byte and then the data bytes. A read uses a repeated start, takes the first byte it receives as the byte count, and ends with a not-acknowledged byte followed by a stop.

A mode input chooses between the full 32-byte buffer and single-byte buffering. With the buffer in use, the host hears from the controller only when a 32-byte boundary is reached or the whole count has moved. In single-byte mode every data byte raises the interrupt, and the controller stalls the engine until the host acknowledges. Counts of zero or above 32, and block writes requested with packet error checking turned on, are refused or aborted and flagged in a sticky error output.

Top module: `smb_blk_xfer`

## Requirements
- R1: The buffer holds 32 bytes. A host write (`hw_en`) stores `hw_data` at the write pointer and advances it. `hr_data` shows the entry at the read pointer, and `hr_en` advances that pointer. Every start taken while idle returns all pointers to entry 0, and each pointer wraps from 31 back to 0.
- R2: A block write issues, in order: op 1 (start, byte `{addr,0}`), op 2 (send the command code), op 2 (send the byte count), op 2 once for each data byte taken from entry 0 upward, and then op 6 (stop).
- R3: A block read issues op 1 `{addr,0}`, op 2 with the command code, op 3 (repeated start, `{addr,1}`) and op 4 (receive the count byte). It then receives the data bytes with op 4, using op 5 (receive with not-acknowledge) for the last one, and finishes with op 6. The received data bytes are stored from entry 0 upward.
- R4: A write start with a byte count of 0 or greater than 32 is refused: no engine request is made, `busy` stays low, and `err` and `irq` are set.
- R5: A write start while `pec_en` is high is refused in the same way as in R4. Reads ignore `pec_en`.
- R6: If a read receives a count byte of 0 or greater than 32, the next request is op 6 and no data byte is requested. `err` and `irq` are set at the moment the count byte is received.
- R7: With buffering on, `irq` is raised in the cycle after the engine completes the last data byte, or a data byte whose running total is a multiple of 32. It is not raised for any other byte. When count = 32 both conditions fall on the same byte and give a single interrupt.
- R8: With buffering off, `irq` is raised after every data byte. No engine request is made until `irq_ack` arrives. A host write made during that wait supplies the next byte to be sent, and `hr_data` shows the byte just received.
- R9: `irq` stays high until `irq_ack`. When a new interrupt event and `irq_ack` fall in the same cycle, the interrupt is kept.
- R10: Host writes are ignored while a transfer is busy, except while it waits for an acknowledge in single-byte mode.
- R11: A `start` while busy is ignored. An accepted start clears `err`.
- R12: An engine request holds `eng_op` and `eng_tx` steady until `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to begin a transaction |
| rd_mode | input | 1 | 1 = block read, 0 = block write |
| buf_en | input | 1 | 1 = 32-byte buffering, 0 = single-byte |
| pec_en | input | 1 | Packet error checking requested (blocks writes) |
| slave_addr | input | 7 | Target address |
| cmd_code | input | 8 | Command code byte |
| byte_count | input | 8 | Data byte count for writes |
| hw_en | input | 1 | Host buffer write strobe |
| hw_data | input | 8 | Host buffer write data |
| hr_en | input | 1 | Host buffer read advance |
| hr_data | output | 8 | Buffer entry at the read pointer |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Transaction in progress |
| err | output | 1 | Sticky error flag |
| eng_req | output | 1 | Engine operation request |
| eng_op | output | 3 | Engine operation code |
| eng_tx | output | 8 | Byte to transmit |
| eng_done | input | 1 | Engine completion pulse |
| eng_rx | input | 8 | Received byte, valid with `eng_done` |

## Verification
Two events can land on the same clock edge. The first is the 32-byte boundary interrupt coinciding with the end-of-count interrupt, which a 32-byte write provokes. The bench judges it by finding `irq` low after every earlier data byte and high after the last one. The second is a new interrupt event coinciding with an acknowledge, which the bench provokes by holding `irq_ack` high through a whole transfer. There the bench requires `irq` to be seen high in the cycle after the final data byte and low again once the transfer is idle.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_START     = 3'd1,
    OP_SEND      = 3'd2,
    OP_RSTART    = 3'd3,
    OP_RECV      = 3'd4,
    OP_RECV_NACK = 3'd5,
    OP_STOP      = 3'd6
  } eng_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_CMD, S_CNT_TX, S_RADDR, S_CNT_RX, S_DATA, S_WAIT, S_STOP
  } xfer_st_e;

  // A byte count is legal when it is non-zero and does not exceed the buffer size.
  function automatic logic count_ok(input logic [7:0] cnt, input logic [7:0] max_cnt);
    return (cnt != 8'd0) && (cnt <= max_cnt);
  endfunction

  // Interrupt point for a completed data byte.
  function automatic logic irq_due(input logic buffered, input logic last, input logic boundary);
    return !buffered || last || boundary;
  endfunction

endpackage

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = 5,
  parameter int unsigned DW    = 8,
  parameter int unsigned NRD   = 2
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rdata
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem_q[raddr[p]];
  end

endmodule

// File: rtl/smb_blk_ptr.sv
module smb_blk_ptr #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hold0,
  input  logic          adv,
  output logic [AW-1:0] ptr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ptr_q <= '0;
    else if (clr || hold0)   ptr_q <= '0;
    else if (adv)            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + AW'(1);
  end

  assign ptr = ptr_q;

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && !hold0 && ptr_q == LAST) |=> (ptr_q == '0));

endmodule

// File: rtl/smb_blk_fsm.sv
module smb_blk_fsm
  import smb_blk_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = 5,
  parameter int unsigned DW    = 8,
  parameter int unsigned SAW   = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           rd_mode,
  input  logic           buf_en,
  input  logic           pec_en,
  input  logic [SAW-1:0] slave_addr,
  input  logic [DW-1:0]  cmd_code,
  input  logic [DW-1:0]  byte_count,
  input  logic           irq_ack,
  input  logic           eng_done,
  input  logic [DW-1:0]  eng_rx,
  input  logic [DW-1:0]  buf_rdata,
  output logic           eng_req,
  output logic [2:0]     eng_op,
  output logic [DW-1:0]  eng_tx,
  output logic           busy,
  output logic           err,
  output logic           irq,
  output logic           store_en,
  output logic           ptr_clr,
  output logic           eptr_adv,
  output logic           buffered,
  output logic           waiting
);

  localparam logic [DW-1:0] MAX_CNT = DW'(DEPTH);

  xfer_st_e       state_q, state_d;
  logic           rd_q, buf_q;
  logic [SAW-1:0] addr_q;
  logic [DW-1:0]  cmd_q, cnt_q, moved_q;
  logic           err_q, irq_q;

  // Named internal events
  logic          start_idle, refuse, accept;
  logic          data_done, cnt_rx_done, cnt_bad;
  logic          last_byte, boundary, irq_set;
  logic [DW-1:0] moved_nx;

  assign start_idle  = start && (state_q == S_IDLE);
  assign refuse      = start_idle && !rd_mode && (pec_en || !count_ok(byte_count, MAX_CNT));
  assign accept      = start_idle && !refuse;
  assign data_done   = (state_q == S_DATA) && eng_done;
  assign cnt_rx_done = (state_q == S_CNT_RX) && eng_done;
  assign cnt_bad     = cnt_rx_done && !count_ok(eng_rx, MAX_CNT);
  assign moved_nx    = moved_q + DW'(1);
  assign last_byte   = (moved_nx == cnt_q);
  assign boundary    = (moved_nx[AW-1:0] == '0);
  assign irq_set     = refuse || cnt_bad || (data_done && irq_due(buf_q, last_byte, boundary));

  // Next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (accept) state_d = S_ADDR;
      S_ADDR:   if (eng_done) state_d = S_CMD;
      S_CMD:    if (eng_done) state_d = rd_q ? S_RADDR : S_CNT_TX;
      S_CNT_TX: if (eng_done) state_d = S_DATA;
      S_RADDR:  if (eng_done) state_d = S_CNT_RX;
      S_CNT_RX: if (eng_done) state_d = cnt_bad ? S_STOP : S_DATA;
      S_DATA:   if (eng_done) state_d = last_byte ? S_STOP : (buf_q ? S_DATA : S_WAIT);
      S_WAIT:   if (irq_ack) state_d = S_DATA;
      S_STOP:   if (eng_done) state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  // Engine request decode
  always_comb begin
    eng_req = 1'b1;
    eng_op  = OP_NONE;
    eng_tx  = '0;
    unique case (state_q)
      S_ADDR:   begin eng_op = OP_START;  eng_tx = DW'({addr_q, 1'b0}); end
      S_CMD:    begin eng_op = OP_SEND;   eng_tx = cmd_q; end
      S_CNT_TX: begin eng_op = OP_SEND;   eng_tx = cnt_q; end
      S_RADDR:  begin eng_op = OP_RSTART; eng_tx = DW'({addr_q, 1'b1}); end
      S_CNT_RX: eng_op = OP_RECV;
      S_DATA: begin
        if (rd_q) eng_op = last_byte ? OP_RECV_NACK : OP_RECV;
        else begin eng_op = OP_SEND; eng_tx = buf_rdata; end
      end
      S_STOP:   eng_op = OP_STOP;
      default:  eng_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rd_q    <= 1'b0;
      buf_q   <= 1'b1;
      addr_q  <= '0;
      cmd_q   <= '0;
      cnt_q   <= '0;
      moved_q <= '0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        rd_q    <= rd_mode;
        buf_q   <= buf_en;
        addr_q  <= slave_addr;
        cmd_q   <= cmd_code;
        cnt_q   <= rd_mode ? '0 : byte_count;
        moved_q <= '0;
      end else begin
        if (cnt_rx_done) cnt_q   <= eng_rx;
        if (data_done)   moved_q <= moved_nx;
      end
      if (refuse || cnt_bad) err_q <= 1'b1;
      else if (accept)       err_q <= 1'b0;
      if (irq_set)           irq_q <= 1'b1;
      else if (irq_ack)      irq_q <= 1'b0;
    end
  end

  assign busy     = (state_q != S_IDLE);
  assign err      = err_q;
  assign irq      = irq_q;
  assign store_en = data_done && rd_q;
  assign ptr_clr  = start_idle;
  assign eptr_adv = data_done;
  assign buffered = buf_q;
  assign waiting  = (state_q == S_WAIT);

  p_req_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_tx)));

  p_refuse_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> (!eng_req && err_q && irq_q));

  p_bad_cnt_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_bad |=> (eng_op == OP_STOP && err_q));

  p_single_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_done && !buf_q && !last_byte) |=> (!eng_req && irq_q));

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_ack) |=> irq_q);

  p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && irq_ack && !irq_set) |=> !irq_q);

  p_moved_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (moved_q <= MAX_CNT));

endmodule

// File: rtl/smb_blk_xfer.sv
module smb_blk_xfer
  import smb_blk_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  parameter int unsigned SAW   = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           rd_mode,
  input  logic           buf_en,
  input  logic           pec_en,
  input  logic [SAW-1:0] slave_addr,
  input  logic [DW-1:0]  cmd_code,
  input  logic [DW-1:0]  byte_count,
  input  logic           hw_en,
  input  logic [DW-1:0]  hw_data,
  input  logic           hr_en,
  output logic [DW-1:0]  hr_data,
  input  logic           irq_ack,
  output logic           irq,
  output logic           busy,
  output logic           err,
  output logic           eng_req,
  output logic [2:0]     eng_op,
  output logic [DW-1:0]  eng_tx,
  input  logic           eng_done,
  input  logic [DW-1:0]  eng_rx
);

  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned NPTR  = 3;  // 0: host write, 1: host read, 2: engine
  localparam int unsigned P_HW  = 0;
  localparam int unsigned P_HR  = 1;
  localparam int unsigned P_ENG = 2;

  logic                     store_en, ptr_clr, eptr_adv, buffered, waiting;
  logic                     hw_ok, hr_ok, host_hold;
  logic [DW-1:0]            buf_eng_rd;
  logic [NPTR-1:0]          p_adv, p_hold;
  logic [NPTR-1:0][AW-1:0]  p_val;
  logic [1:0][AW-1:0]       rd_addr;
  logic [1:0][DW-1:0]       rd_data;
  logic                     buf_we;
  logic [AW-1:0]            buf_waddr;
  logic [DW-1:0]            buf_wdata;

  // Host access gating
  assign hw_ok     = hw_en && (!busy || waiting);
  assign hr_ok     = hr_en && !busy;
  assign host_hold = busy ? !buffered : !buf_en;

  assign p_adv[P_HW]   = hw_ok;
  assign p_adv[P_HR]   = hr_ok;
  assign p_adv[P_ENG]  = eptr_adv;
  assign p_hold[P_HW]  = host_hold;
  assign p_hold[P_HR]  = host_hold;
  assign p_hold[P_ENG] = busy && !buffered;

  for (genvar k = 0; k < NPTR; k++) begin : g_ptr
    smb_blk_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ptr_clr),
      .hold0 (p_hold[k]),
      .adv   (p_adv[k]),
      .ptr   (p_val[k])
    );
  end

  // Engine-side stores take the write port; host writes are gated off then.
  assign buf_we    = store_en || hw_ok;
  assign buf_waddr = store_en ? p_val[P_ENG] : p_val[P_HW];
  assign buf_wdata = store_en ? eng_rx : hw_data;
  assign rd_addr[0] = p_val[P_HR];
  assign rd_addr[1] = p_val[P_ENG];

  smb_blk_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .NRD(2)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  assign hr_data    = rd_data[0];
  assign buf_eng_rd = rd_data[1];

  smb_blk_fsm #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .SAW(SAW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .rd_mode    (rd_mode),
    .buf_en     (buf_en),
    .pec_en     (pec_en),
    .slave_addr (slave_addr),
    .cmd_code   (cmd_code),
    .byte_count (byte_count),
    .irq_ack    (irq_ack),
    .eng_done   (eng_done),
    .eng_rx     (eng_rx),
    .buf_rdata  (buf_eng_rd),
    .eng_req    (eng_req),
    .eng_op     (eng_op),
    .eng_tx     (eng_tx),
    .busy       (busy),
    .err        (err),
    .irq        (irq),
    .store_en   (store_en),
    .ptr_clr    (ptr_clr),
    .eptr_adv   (eptr_adv),
    .buffered   (buffered),
    .waiting    (waiting)
  );

  p_pec_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(pec_en && !rd_mode));

  p_wr_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_en && hw_en && busy && !waiting && buffered) || !hw_ok);

  p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |-> !ptr_clr);

endmodule

// File: tb/smb_blk_xfer_tb.sv
module smb_blk_xfer_tb_top;

  localparam int CLK_P = 10;
  localparam logic [6:0] ADDR = 7'h2A;
  localparam logic [7:0] CMD  = 8'hC3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, rd_mode = 1'b0, buf_en = 1'b1, pec_en = 1'b0;
  logic [6:0] slave_addr = ADDR;
  logic [7:0] cmd_code = CMD, byte_count = 8'd0;
  logic       hw_en = 1'b0, hr_en = 1'b0, irq_ack = 1'b0;
  logic [7:0] hw_data = 8'd0, hr_data;
  logic       irq, busy, err, eng_req;
  logic [2:0] eng_op;
  logic [7:0] eng_tx;
  logic       eng_done = 1'b0;
  logic [7:0] eng_rx = 8'd0;

  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  // Engine model log
  logic [2:0] log_op [64];
  logic [7:0] log_tx [64];
  logic       irq_after [64];
  int         n_log = 0;
  logic [7:0] slv [64];
  int         rx_i = 0;
  logic [7:0] pat [64];

  always #(CLK_P/2) clk = ~clk;

  smb_blk_xfer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode), .buf_en(buf_en),
    .pec_en(pec_en), .slave_addr(slave_addr), .cmd_code(cmd_code), .byte_count(byte_count),
    .hw_en(hw_en), .hw_data(hw_data), .hr_en(hr_en), .hr_data(hr_data),
    .irq_ack(irq_ack), .irq(irq), .busy(busy), .err(err),
    .eng_req(eng_req), .eng_op(eng_op), .eng_tx(eng_tx), .eng_done(eng_done), .eng_rx(eng_rx)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  // Byte-level engine model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && eng_req && !eng_done && n_log < 64) begin
        log_op[n_log] = eng_op;
        log_tx[n_log] = eng_tx;
        repeat (2) @(negedge clk);
        chk("R12", {eng_req, eng_op, eng_tx}, {1'b1, log_op[n_log], log_tx[n_log]}, "request held");
        if (eng_op == 3'd4 || eng_op == 3'd5) begin
          eng_rx = slv[rx_i];
          rx_i++;
        end
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        irq_after[n_log] = irq;
        n_log++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  task automatic hwrite(input logic [7:0] d);
    @(negedge clk); hw_en = 1'b1; hw_data = d;
    @(negedge clk); hw_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy || eng_done) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_log();
    n_log = 0; rx_i = 0;
  endtask

  task automatic expect_op(input string req, input int idx, input logic [2:0] op, input logic [7:0] tx, input bit cmp_tx);
    chk(req, log_op[idx], op, $sformatf("op[%0d]", idx));
    if (cmp_tx) chk(req, log_tx[idx], tx, $sformatf("tx[%0d]", idx));
  endtask

  // R2 R7 R10 R11: buffered write of n bytes
  task automatic t_buf_write(input int n, input bit poke_busy);
    buf_en = 1'b1; rd_mode = 1'b0; pec_en = 1'b0; byte_count = 8'(n);
    for (int i = 0; i < n; i++) begin pat[i] = 8'(8'h11 * (i + 3) + n); hwrite(pat[i]); end
    clear_log();
    pulse_start();
    chk("R11", err, 0, "err cleared by accepted start");
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      hwrite(8'hEE);               // R10: ignored while busy
      rd_mode = 1'b1;
      pulse_start();               // R11: ignored while busy
      rd_mode = 1'b0;
    end
    wait_idle();
    chk("R2", n_log, n + 4, "op count");
    expect_op("R2", 0, 3'd1, {ADDR, 1'b0}, 1);
    expect_op("R2", 1, 3'd2, CMD, 1);
    expect_op("R2", 2, 3'd2, 8'(n), 1);
    for (int i = 0; i < n; i++) begin
      expect_op("R2", 3 + i, 3'd2, pat[i], 1);
      chk("R7", irq_after[3 + i], (i == n - 1) ? 1 : 0, $sformatf("irq after data %0d", i));
    end
    expect_op("R2", n + 3, 3'd6, 8'd0, 0);
    chk("R7", irq, 1, "irq pending at end");
    if (poke_busy) chk("R10", hr_data, pat[0], "entry 0 untouched by busy write");
    ack();
    chk("R9", irq, 0, "irq cleared by ack");
  endtask

  // R1: write pointer wrap, 33rd byte lands on entry 0
  task automatic t_wrap();
    buf_en = 1'b1; rd_mode = 1'b0; byte_count = 8'd32;
    for (int i = 0; i < 33; i++) hwrite(8'(i + 8'h40));
    clear_log();
    pulse_start();
    wait_idle();
    chk("R1", log_tx[3], 8'(32 + 8'h40), "wrapped byte sent first");
    chk("R1", log_tx[4], 8'h41, "entry 1 sent second");
    ack();
  endtask

  // R3 R7 R1: buffered read
  task automatic t_buf_read(input int n);
    buf_en = 1'b1; rd_mode = 1'b1;
    slv[0] = 8'(n);
    for (int i = 0; i < n; i++) slv[1 + i] = 8'(8'hA0 ^ (i * 7));
    clear_log();
    pulse_start();
    wait_idle();
    chk("R3", n_log, n + 5, "op count");
    expect_op("R3", 0, 3'd1, {ADDR, 1'b0}, 1);
    expect_op("R3", 1, 3'd2, CMD, 1);
    expect_op("R3", 2, 3'd3, {ADDR, 1'b1}, 1);
    expect_op("R3", 3, 3'd4, 8'd0, 0);
    for (int i = 0; i < n; i++) begin
      expect_op("R3", 4 + i, (i == n - 1) ? 3'd5 : 3'd4, 8'd0, 0);
      chk("R7", irq_after[4 + i], (i == n - 1) ? 1 : 0, $sformatf("read irq after %0d", i));
    end
    expect_op("R3", n + 4, 3'd6, 8'd0, 0);
    for (int i = 0; i < n; i++) begin
      chk("R1", hr_data, slv[1 + i], $sformatf("drain entry %0d", i));
      @(negedge clk); hr_en = 1'b1;
      @(negedge clk); hr_en = 1'b0;
    end
    ack();
  endtask

  // R6: illegal count byte from the target
  task automatic t_read_bad(input logic [7:0] c);
    buf_en = 1'b1; rd_mode = 1'b1; slv[0] = c;
    clear_log();
    pulse_start();
    wait_idle();
    chk("R6", n_log, 5, "ops before abort");
    expect_op("R6", 4, 3'd6, 8'd0, 0);
    chk("R6", irq_after[3], 1, "irq at count byte");
    chk("R6", err, 1, "err set");
    ack();
  endtask

  // R4 R5: refused write starts
  task automatic t_refuse(input logic [7:0] c, input logic pec, input string req);
    buf_en = 1'b1; rd_mode = 1'b0; byte_count = c; pec_en = pec;
    clear_log();
    pulse_start();
    chk(req, {busy, err, irq}, 3'b011, "refused state");
    repeat (5) @(negedge clk);
    chk(req, n_log + int'(eng_req), 0, "no engine request");
    pec_en = 1'b0;
    ack();
  endtask

  // R8: single-byte write
  task automatic t_single_write(input int n);
    buf_en = 1'b0; rd_mode = 1'b0; byte_count = 8'(n);
    for (int i = 0; i < n; i++) pat[i] = 8'(8'h5C + 9 * i);
    hwrite(pat[0]);
    clear_log();
    pulse_start();
    for (int i = 0; i < n; i++) begin
      while (!irq) @(negedge clk);
      if (i < n - 1) begin
        repeat (3) @(negedge clk);
        chk("R8", eng_req, 0, "stalled until ack");
        hwrite(pat[i + 1]);
      end
      ack();
    end
    wait_idle();
    for (int i = 0; i < n; i++) expect_op("R8", 3 + i, 3'd2, pat[i], 1);
    expect_op("R8", n + 3, 3'd6, 8'd0, 0);
  endtask

  // R8: single-byte read
  task automatic t_single_read(input int n);
    buf_en = 1'b0; rd_mode = 1'b1;
    slv[0] = 8'(n);
    for (int i = 0; i < n; i++) slv[1 + i] = 8'(8'h37 + 5 * i);
    clear_log();
    pulse_start();
    for (int i = 0; i < n; i++) begin
      while (!irq) @(negedge clk);
      chk("R8", hr_data, slv[1 + i], $sformatf("single read byte %0d", i));
      ack();
    end
    wait_idle();
    chk("R8", n_log, n + 5, "single read op count");
  endtask

  // R9: acknowledge held during the final interrupt event
  task automatic t_ack_collide();
    buf_en = 1'b1; rd_mode = 1'b0; byte_count = 8'd2;
    hwrite(8'h01); hwrite(8'h02);
    clear_log();
    @(negedge clk); irq_ack = 1'b1;
    pulse_start();
    wait_idle();
    chk("R9", irq_after[4], 1, "set wins over ack");
    chk("R9", irq, 0, "ack clears afterwards");
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {irq, busy, err, eng_req}, 4'b0000, "reset state");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_refuse(8'd0, 1'b0, "R4");
    t_buf_write(5, 1'b1);
    t_refuse(8'd33, 1'b0, "R4");
    t_refuse(8'd4, 1'b1, "R5");
    t_buf_write(1, 1'b0);
    t_buf_write(32, 1'b0);
    t_wrap();
    t_buf_read(6);
    t_read_bad(8'd0);
    t_read_bad(8'd40);
    pec_en = 1'b1;
    t_buf_read(3);               // R5: reads ignore pec_en
    pec_en = 1'b0;
    t_single_write(3);
    t_single_read(3);
    t_ack_collide();
    summary();
  end

endmodule